// File: doc/BRIEF.md
# Register-Mapped MDIO Management Bridge

This block turns a single 32-bit command word into one complete management transaction on an MDC/MDIO bus, using the IEEE 802.3 Clause 22 frame. The host writes the word with a one-cycle strobe. The block then generates MDC and shifts the frame out. For a read, it releases the data line at turnaround and collects the sixteen bits the PHY returns. When the frame ends it raises a completion flag. The host polls the same register until that flag appears, then takes read data from the low half.

The command port has no back-pressure. While a frame is in flight the block refuses new commands: a write strobe in that window is dropped and leaves no trace. The host must therefore wait for completion before it issues the next command. The MDIO pins stay plain control signals: an output value, an output enable and an input. The pad and its pull-up sit outside the block.

Top module: `mdio_cmd_bridge`

## Requirements
- R1: After reset the register reads all zeros, MDC is low and the MDIO output enable is low.
- R2: Register layout: bit 31 completion flag, bit 30 turnaround-error flag, bits 29:28 start code (01), bits 27:26 opcode (01 write, 11 read), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data.
- R3: A write strobe while idle loads bits 29:0 from the written word and starts a frame; in the next cycle the register reads back with bits 31 and 30 both zero.
- R4: Each frame is sent most significant bit first: 32 preamble ones, start code, opcode, PHY address, register address, a two-bit turnaround, then 16 data bits. In a write frame the block drives the turnaround as 1 then 0.
- R5: MDC has a period of MDC_DIV system clocks while a frame runs, and it is low when idle. The MDIO output changes only on the clock edge where MDC falls. MDIO input is sampled on the edge where MDC rises.
- R6: In a read frame, the output enable goes low from the first turnaround bit to the end of the frame. On completion, bits 15:0 hold the 16 bits sampled in the data phase, first sample in bit 15.
- R7: In a read frame, if the second turnaround bit is sampled high, bit 30 is set at completion; the completion flag is set as well.
- R8: A write strobe that arrives while a frame is in flight is ignored. The register is unchanged and no further frame is sent.
- R9: When a write frame completes, bit 31 sets and bits 29:0 keep the command as written.
- R10: Once a frame completes, the output enable is low and MDC is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | One-cycle command register write strobe |
| reg_wr_data | input | 32 | Command word written with the strobe |
| reg_rd_data | output | 32 | Current command/status register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
Two situations are hard to bring about from the ports. The first is a command that collides with a frame in flight. The bench issues a read, waits about forty system clocks so that the frame is deep in its preamble, and strobes a different command. It then checks that the register did not change and that the PHY model counted exactly one frame. The second is a turnaround error. The behavioural PHY answers only addresses 1 and 2, so a read to address 5 leaves the pulled-up line high through turnaround and the data phase. This gives the error flag and all-ones data without any fault injection.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef struct packed {
    logic        done;
    logic        ta_err;
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_cmd_t;

  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b11;
  localparam logic [1:0] TA_DRIVEN = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int MDC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = MDC_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CW'(HALF - 1));
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: the clock parks low whenever no frame is running
  a_r5_mdc_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [29:0] body,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        finish,
  output logic        ta_bad,
  output logic [15:0] rd_data
);
  localparam int FRAME      = PREAMBLE_BITS + 32;
  localparam int IW         = $clog2(FRAME);
  localparam int TA_FIRST   = PREAMBLE_BITS + 14;
  localparam int TA_SECOND  = PREAMBLE_BITS + 15;
  localparam int DATA_FIRST = PREAMBLE_BITS + 16;
  localparam int LAST       = FRAME - 1;

  logic [FRAME-1:0] shreg;
  logic [FRAME-1:0] frame_word;
  logic [IW-1:0]    idx;
  logic             is_rd;

  assign frame_word = {{PREAMBLE_BITS{1'b1}}, body[29:16], TA_DRIVEN, body[15:0]};
  assign mdio_o     = shreg[FRAME-1];
  assign finish     = busy && fall_evt && (idx == IW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      mdio_oe <= 1'b0;
      ta_bad  <= 1'b0;
      rd_data <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      shreg   <= frame_word;
      idx     <= '0;
      is_rd   <= (body[27:26] == OP_READ);
      mdio_oe <= 1'b1;
      ta_bad  <= 1'b0;
      rd_data <= '0;
    end else if (busy) begin
      if (fall_evt) begin
        if (idx == IW'(LAST)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME-2:0], 1'b0};
          if (is_rd && (idx == IW'(TA_FIRST - 1)))
            mdio_oe <= 1'b0;
        end
      end
      if (rise_evt && is_rd) begin
        if (idx == IW'(TA_SECOND))
          ta_bad <= mdio_i;
        if (idx >= IW'(DATA_FIRST))
          rd_data <= {rd_data[14:0], mdio_i};
      end
    end
  end

  // R6: a read frame never drives the line after turnaround begins
  a_r6_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && idx >= IW'(TA_FIRST)) |-> !mdio_oe);
  // R4: a write frame keeps the line driven for its whole length
  a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_rd) |-> mdio_oe);
  // R5: inside a frame the output moves only with a falling MDC step
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_evt));

endmodule

// File: rtl/mdio_cmd_bridge.sv
module mdio_cmd_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int MDC_DIV       = 4,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t   cmd_q;
  logic        busy;
  logic        accept;
  logic        finish;
  logic        ta_bad;
  logic [15:0] rd_data;
  logic        rise_evt;
  logic        fall_evt;

  assign accept      = reg_wr_en && !busy;
  assign reg_rd_data = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q        <= mdio_cmd_t'(reg_wr_data);
      cmd_q.done   <= 1'b0;
      cmd_q.ta_err <= 1'b0;
    end else if (finish) begin
      cmd_q.done   <= 1'b1;
      cmd_q.ta_err <= ta_bad;
      if (cmd_q.op == OP_READ)
        cmd_q.data <= rd_data;
    end
  end

  mdio_mdc_gen #(.MDC_DIV(MDC_DIV)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_engine #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .body     (reg_wr_data[29:0]),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .finish   (finish),
    .ta_bad   (ta_bad),
    .rd_data  (rd_data)
  );

  // R3: an accepted command clears both status flags one cycle later
  a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (reg_rd_data[31:30] == 2'b00));
  // R8: a strobe during a frame leaves the register untouched
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && reg_wr_en) |=> $stable(reg_rd_data));
  // R7: a turnaround error can only follow a read opcode
  a_r7_err_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[30] |-> (reg_rd_data[27:26] == OP_READ));
  // R10: completion implies the bus is released and idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[31] |-> (!busy && !mdio_oe && !mdc));

endmodule

// File: tb/mdio_cmd_bridge_tb_top.sv
module mdio_cmd_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int FRAME      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_cmd_bridge #(.MDC_DIV(DIV), .PREAMBLE_BITS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural PHY (answers addresses 1 and 2) ----------------
  logic [15:0] phy_mem [1:2][0:31];
  int          phy_cnt = 0;
  int          frames_seen = 0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;

  initial begin
    for (int p = 1; p <= 2; p++)
      for (int r = 0; r < 32; r++)
        phy_mem[p][r] = 16'hA500 | 16'(p << 5) | 16'(r);
  end

  function automatic bit phy_valid(input logic [4:0] a);
    return (a == 5'd1) || (a == 5'd2);
  endfunction

  always @(posedge mdc) begin
    if (phy_cnt == FRAME) phy_cnt = 0;
    cap_bits[FRAME-1-phy_cnt] = mdio_o;
    cap_oe[FRAME-1-phy_cnt]   = mdio_oe;
    phy_cnt++;
    if (phy_cnt == FRAME) begin
      frames_seen++;
      if (cap_bits[29:28] == 2'b01 && phy_valid(cap_bits[27:23]) && cap_oe == '1)
        phy_mem[cap_bits[27:23]][cap_bits[22:18]] = cap_bits[15:0];
    end
  end

  always @(negedge mdc) begin
    if (phy_cnt >= 47 && phy_cnt < FRAME && cap_bits[29:28] == 2'b11 &&
        phy_valid(cap_bits[27:23])) begin
      if (phy_cnt == 47) mdio_i = 1'b0;
      else mdio_i = phy_mem[cap_bits[27:23]][cap_bits[22:18]][63-phy_cnt];
    end else begin
      mdio_i = 1'b1;
    end
  end

  // ---------------- MDC timing monitor ----------------
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
  int   since_rise = -1;
  int   last_period = 0;
  int   edge_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && !prev_mdc) begin
        if (since_rise >= 0) last_period = since_rise + 1;
        since_rise = 0;
      end else if (since_rise >= 0 && mdio_oe) begin
        since_rise++;
      end
      if (!mdio_oe) since_rise = -1;
      if (prev_oe && mdio_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc))
        edge_viol++;
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        seen_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_rd_data[31] && !seen_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected completion", 64'(reg_rd_data), 64'(0));
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(reg_rd_data == e, t, "register at completion", 64'(reg_rd_data), 64'(e));
        end
      end
      seen_done = reg_rd_data[31];
    end
  end

  // ---------------- driver ----------------
  task automatic pulse_write(input logic [31:0] w);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_data = w;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!reg_rd_data[31] && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic check_frame(input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] d);
    logic [63:0] eb, eo;
    eb = {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, d};
    eo = (op == 2'b11) ? {{46{1'b1}}, 18'b0} : '1;
    check(cap_oe == eo, (op == 2'b11) ? "R6" : "R4", "enable pattern", cap_oe, eo);
    check(((cap_bits ^ eb) & eo) == '0, "R4", "driven frame bits", cap_bits & eo, eb & eo);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d, input logic [15:0] exp_d,
                         input logic exp_ta, input string tag);
    logic [31:0] w;
    w = {2'b00, 2'b01, op, phy, ra, d};
    exp_q.push_back({1'b1, exp_ta, 2'b01, op, phy, ra, exp_d});
    tag_q.push_back(tag);
    pulse_write(w);
    check(reg_rd_data == w, "R3", "flags cleared and command loaded",
          64'(reg_rd_data), 64'(w));
    wait_done();
    @(negedge clk);
    check(!mdio_oe && !mdc, "R10", "bus idle after completion",
          64'({mdio_oe, mdc}), 64'(0));
    check_frame(op, phy, ra, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rd_data == 32'h0, "R1", "register after reset", 64'(reg_rd_data), 64'(0));
    check(!mdc && !mdio_oe, "R1", "pins after reset", 64'({mdc, mdio_oe}), 64'(0));

    // R9: writes complete with the command kept intact
    run_cmd(2'b01, 5'd1, 5'd3, 16'h1234, 16'h1234, 1'b0, "R9");
    check(last_period == DIV, "R5", "MDC period", 64'(last_period), 64'(DIV));
    run_cmd(2'b01, 5'd2, 5'd3, 16'hBEEF, 16'hBEEF, 1'b0, "R9");
    // R6: reads return the PHY contents
    run_cmd(2'b11, 5'd1, 5'd3, 16'h0000, 16'h1234, 1'b0, "R6");
    run_cmd(2'b11, 5'd2, 5'd3, 16'h5A5A, 16'hBEEF, 1'b0, "R6");
    run_cmd(2'b11, 5'd2, 5'd17, 16'h0000, 16'hA551, 1'b0, "R6");
    // R7: absent PHY leaves turnaround high
    run_cmd(2'b11, 5'd5, 5'd0, 16'h0000, 16'hFFFF, 1'b1, "R7");
    check(reg_rd_data[30], "R7", "turnaround error flag", 64'(reg_rd_data[30]), 64'(1));

    // R8: collision with a frame in flight
    begin
      logic [31:0] wa, wb;
      int f0;
      wa = {2'b00, 2'b01, 2'b11, 5'd1, 5'd3, 16'h0000};
      wb = {2'b00, 2'b01, 2'b01, 5'd2, 5'd9, 16'h7777};
      exp_q.push_back({1'b1, 1'b0, 2'b01, 2'b11, 5'd1, 5'd3, 16'h1234});
      tag_q.push_back("R8");
      f0 = frames_seen;
      pulse_write(wa);
      repeat (40) @(negedge clk);
      pulse_write(wb);
      check(reg_rd_data == wa, "R8", "register kept during frame",
            64'(reg_rd_data), 64'(wa));
      wait_done();
      repeat (4 * DIV) @(negedge clk);
      check(frames_seen - f0 == 1, "R8", "frames sent", 64'(frames_seen - f0), 64'(1));
      check(phy_mem[2][9] == 16'hA549, "R8", "dropped write reached PHY",
            64'(phy_mem[2][9]), 64'(16'hA549));
    end

    check(edge_viol == 0, "R5", "MDIO changes off falling MDC", 64'(edge_viol), 64'(0));
    check(exp_q.size() == 0, "R2", "scoreboard drained", 64'(exp_q.size()), 64'(0));
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<100000", wd);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule